// File: doc/BRIEF.md
# Nonvolatile Byte Store Register Unit

This block gives a small processor two memory-mapped registers through which it reads and programs an on-chip byte-wide nonvolatile array. One register holds a byte on its way to or from the array. The other carries the command and status bits: a ready-interrupt enable, a write arm bit, a write strobe and a read strobe. The array address comes from an address register that lives outside the block. The array itself is modelled as a plain synchronous byte memory whose programming time is a parameter.

A write needs two steps. Software first sets the arm bit. Within the next four clocks it must then set the write strobe. The arm bit lapses on its own, so a late strobe does nothing. While a write is programming, the strobe reads back as one. The block raises a level interrupt whenever it is idle and both the interrupt enable and the processor's global interrupt flag are set. If the data byte or the address changes while a write is running, the write stops early and a sticky flag records this. Every accepted strobe holds the processor for a fixed number of cycles.

Top module: `nvm_regs`

## Requirements
- R1: After reset the data register (address 0x1D) and the control register (address 0x1C) read 0x00, and `irq` and `stall` are low.
- R2: Control bits 7:4 always read zero, and writing ones to them changes no other bit.
- R3: Writing a control byte with bit 2 (arm) set makes bit 2 read one for exactly MWE_CYCLES (4) cycles, after which hardware clears it.
- R4: Writing control bit 1 (write strobe) while the arm bit is clear has no effect: bit 1 stays zero, nothing is stalled and the array is unchanged.
- R5: A write strobe accepted while armed makes bit 1 read one for exactly WR_CYCLES cycles. When the strobe clears, the data register byte is stored at `nvm_addr`.
- R6: `irq` equals control bit 3 AND `gie` AND NOT bit 1, every cycle.
- R7: Writing control bit 0 (read strobe) while idle loads the array byte at `nvm_addr` into the data register at that clock edge. Bit 0 then reads one for RD_STALL (4) cycles and clears itself.
- R8: `stall` is high for WR_STALL (2) cycles after an accepted write strobe and for RD_STALL (4) cycles after an accepted read strobe.
- R9: A data register write, or an `addr_wr` pulse, during a write ends the write at that edge. Bit 1 clears and `wr_abort` goes high. `wr_abort` stays high until the next write strobe is accepted.
- R10: A read strobe issued while a write is running is ignored: the data register is unchanged, `stall` stays low and the write continues.
- R11: When bits 1 and 0 are set in the same control write while armed, only the write starts: `stall` lasts WR_STALL cycles, bit 0 stays zero and the data register is unchanged.
- R12: Register addresses other than 0x1C and 0x1D read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register port select |
| we | input | 1 | Register write enable (with sel) |
| addr | input | 6 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Combinational register read data |
| nvm_addr | input | AW | Array address from the external address register |
| addr_wr | input | 1 | Pulse: external address register is being written |
| gie | input | 1 | Processor global interrupt flag |
| irq | output | 1 | Level ready interrupt |
| stall | output | 1 | Processor hold request |
| wr_abort | output | 1 | Sticky flag: last write was cut short |

## Verification
The assertions assume a well-behaved processor: no register access while `stall` is high, `addr_wr` comes as single-cycle pulses, and `nvm_addr` is held steady from a strobe until its access ends. The bench keeps to this by driving each bus access for one cycle at a falling edge. It waits out every stall and every write by counting cycles or polling the control register. It changes `nvm_addr` or pulses `addr_wr` only when a check calls for an abort.

// File: rtl/nvm_regs.sv
module nvm_regs #(
  parameter int AW         = 6,
  parameter int WR_CYCLES  = 2080,
  parameter int MWE_CYCLES = 4,
  parameter int WR_STALL   = 2,
  parameter int RD_STALL   = 4,
  parameter logic [5:0] DATA_ADDR = 6'h1D,
  parameter logic [5:0] CTRL_ADDR = 6'h1C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          we,
  input  logic [5:0]    addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic [AW-1:0] nvm_addr,
  input  logic          addr_wr,
  input  logic          gie,
  output logic          irq,
  output logic          stall,
  output logic          wr_abort
);
  localparam int DEPTH = 1 << AW;
  localparam int WW = $clog2(WR_CYCLES + 1);
  localparam int MW = $clog2(MWE_CYCLES + 1);
  localparam int SMAX = (WR_STALL > RD_STALL) ? WR_STALL : RD_STALL;
  localparam int SW = $clog2(SMAX + 1);

  logic [7:0]    mem [DEPTH];
  logic [7:0]    data_q;
  logic          rie, mwe, wbusy, rbit;
  logic [MW-1:0] mwe_cnt;
  logic [WW-1:0] wcnt;
  logic [SW-1:0] scnt;

  wire ctrl_wr = sel & we & (addr == CTRL_ADDR);
  wire data_wr = sel & we & (addr == DATA_ADDR);
  wire wr_go   = ctrl_wr & wdata[1] & mwe & ~wbusy;
  wire rd_go   = ctrl_wr & wdata[0] & ~wbusy & ~wr_go;
  wire abort   = wbusy & (data_wr | addr_wr);
  wire commit  = wbusy & ~abort & (wcnt == '0);

  assign irq   = rie & gie & ~wbusy;
  assign stall = (scnt != '0);
  assign rdata = !sel                ? 8'h00 :
                 (addr == DATA_ADDR) ? data_q :
                 (addr == CTRL_ADDR) ? {4'h0, rie, mwe, wbusy, rbit} : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q   <= '0;
      rie      <= 1'b0;
      mwe      <= 1'b0;
      mwe_cnt  <= '0;
      wbusy    <= 1'b0;
      wcnt     <= '0;
      rbit     <= 1'b0;
      scnt     <= '0;
      wr_abort <= 1'b0;
    end else begin
      if (ctrl_wr) rie <= wdata[3];

      if (ctrl_wr && wdata[2]) begin
        mwe     <= 1'b1;
        mwe_cnt <= MW'(MWE_CYCLES - 1);
      end else if (mwe) begin
        if (mwe_cnt == '0) mwe <= 1'b0;
        else mwe_cnt <= mwe_cnt - 1'b1;
      end

      if (data_wr)    data_q <= wdata;
      else if (rd_go) data_q <= mem[nvm_addr];

      if (wr_go) begin
        wbusy    <= 1'b1;
        wcnt     <= WW'(WR_CYCLES - 1);
        wr_abort <= 1'b0;
      end else if (wbusy) begin
        if (abort) begin
          wbusy    <= 1'b0;
          wr_abort <= 1'b1;
        end else if (wcnt == '0) begin
          wbusy <= 1'b0;
        end else begin
          wcnt <= wcnt - 1'b1;
        end
      end

      if (wr_go) begin
        scnt <= SW'(WR_STALL);
      end else if (rd_go) begin
        scnt <= SW'(RD_STALL);
        rbit <= 1'b1;
      end else if (scnt != '0) begin
        scnt <= scnt - 1'b1;
        if (scnt == SW'(1)) rbit <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[nvm_addr] <= data_q;
  end

  AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[7:4] != 4'h0) |=> (rie == $past(wdata[3]))); // R2
  AST_MWE_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (mwe && mwe_cnt == '0 && !(ctrl_wr && wdata[2])) |=> !mwe); // R3
  AST_NO_UNARMED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wbusy && ctrl_wr && !mwe) |=> !wbusy); // R4
  AST_IRQ_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wbusy |-> !irq); // R6
  AST_STALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wbusy) |-> stall); // R8
  AST_ABORT_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wbusy && data_wr) |=> (!wbusy && wr_abort)); // R9
  AST_RD_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wbusy && ctrl_wr && wdata[0]) |=> ($stable(data_q) && !rbit)); // R10
endmodule

// File: tb/nvm_regs_test.sv
module nvm_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int WRC = 12;
  localparam logic [5:0] DA = 6'h1D;
  localparam logic [5:0] CA = 6'h1C;
  localparam int NV = 6;
  localparam logic [13:0] VEC [NV] = '{
    {6'd0, 8'hA5}, {6'd1, 8'h3C}, {6'd17, 8'hFF},
    {6'd42, 8'h00}, {6'd62, 8'h81}, {6'd63, 8'h5A}};

  logic clk = 0, rst_n = 0, sel = 0, we = 0, addr_wr = 0, gie = 0;
  logic [5:0] addr = 0, nvm_addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic irq, stall, wr_abort;
  int checks = 0, fails = 0, cyc = 0;

  nvm_regs #(.WR_CYCLES(WRC)) uut (.clk, .rst_n, .sel, .we, .addr, .wdata, .rdata,
    .nvm_addr, .addr_wr, .gie, .irq, .stall, .wr_abort);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      fails = fails + 1; checks = checks + 1;
      $display("FAIL watchdog expired act=%0d exp=<50000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic bw(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] v);
    sel = 1; we = 0; addr = a; #1; v = rdata; sel = 0;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    rd(CA, v);
    while (v[1]) begin @(negedge clk); rd(CA, v); end
  endtask

  task automatic nvm_write(input logic [5:0] a, input logic [7:0] d, output int busy_n);
    logic [7:0] v;
    nvm_addr = a; bw(DA, d); bw(CA, 8'h04); bw(CA, 8'h02);
    busy_n = 0; rd(CA, v);
    while (v[1]) begin busy_n++; @(negedge clk); rd(CA, v); end
  endtask

  initial begin
    logic [7:0] v, d0;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(DA, v); chk(v == 8'h00, "R1 data reset", v, 0);
    rd(CA, v); chk(v == 8'h00, "R1 ctrl reset", v, 0);
    chk(!irq && !stall, "R1 irq/stall reset", {irq, stall}, 0);

    for (int i = 0; i < NV; i++) begin
      nvm_write(VEC[i][13:8], VEC[i][7:0], n);
      chk(n == WRC, "R5 busy length", n, WRC);
    end
    for (int i = 0; i < NV; i++) begin
      nvm_addr = VEC[i][13:8];
      bw(CA, 8'h01);
      rd(CA, v); chk(v[0] && stall, "R7 read strobe set", v, 1);
      rd(DA, v); chk(v == VEC[i][7:0], "R5 R7 readback", v, VEC[i][7:0]);
      n = 0; while (stall) begin n++; @(negedge clk); end
      chk(n == 4, "R8 read stall", n, 4);
      rd(CA, v); chk(v[0] == 0, "R7 read strobe cleared", v, 0);
    end

    bw(CA, 8'hF0); rd(CA, v); chk(v == 8'h00, "R2 reserved bits", v, 0);

    bw(CA, 8'h04); rd(CA, v); chk(v[2], "R3 arm set", v, 4);
    repeat (3) @(negedge clk);
    rd(CA, v); chk(v[2], "R3 arm 4th cycle", v, 4);
    @(negedge clk); rd(CA, v); chk(!v[2], "R3 arm expired", v, 0);

    nvm_addr = 6'd1; bw(DA, 8'h77); bw(CA, 8'h02);
    rd(CA, v); chk(v == 8'h00 && !stall, "R4 unarmed strobe", v, 0);
    bw(CA, 8'h01); rd(DA, v); chk(v == 8'h3C, "R4 array unchanged", v, 8'h3C);
    repeat (4) @(negedge clk);

    gie = 1; bw(CA, 8'h08); #1; chk(irq, "R6 irq idle", irq, 1);
    nvm_addr = 6'd5; bw(DA, 8'h99); bw(CA, 8'h0C); bw(CA, 8'h0A);
    chk(!irq, "R6 irq busy", irq, 0);
    n = 0; while (stall) begin n++; @(negedge clk); end
    chk(n == 2, "R8 write stall", n, 2);
    d0 = 8'h99; nvm_addr = 6'd0;
    bw(CA, 8'h09);
    rd(DA, v); chk(v == d0 && !stall, "R10 read during write ignored", v, d0);
    rd(CA, v); chk(v[1] && !v[0], "R10 write continues", v, 2);
    nvm_addr = 6'd5; wait_idle();
    bw(CA, 8'h08); #1; chk(irq, "R6 irq after write", irq, 1);
    gie = 0; #1; chk(!irq, "R6 irq gie low", irq, 0);

    nvm_write(6'd7, 8'h11, n);
    bw(DA, 8'h22); bw(CA, 8'h04); bw(CA, 8'h02);
    repeat (3) @(negedge clk);
    bw(DA, 8'h33);
    rd(CA, v); chk(!v[1] && wr_abort, "R9 data abort", {v, 7'b0, wr_abort}, 1);
    nvm_write(6'd8, 8'h44, n);
    chk(!wr_abort, "R9 flag cleared", wr_abort, 0);
    bw(CA, 8'h04); bw(CA, 8'h02);
    repeat (2) @(negedge clk);
    addr_wr = 1; @(negedge clk); addr_wr = 0;
    rd(CA, v); chk(!v[1] && wr_abort, "R9 addr abort", {v, 7'b0, wr_abort}, 1);

    nvm_addr = 6'd9; bw(DA, 8'h6E); bw(CA, 8'h04); bw(CA, 8'h03);
    rd(CA, v); chk(v[1] && !v[0], "R11 write wins", v, 2);
    n = 0; while (stall) begin n++; @(negedge clk); end
    chk(n == 2, "R11 write stall only", n, 2);
    rd(DA, v); chk(v == 8'h6E, "R11 data unchanged", v, 8'h6E);
    wait_idle();
    nvm_addr = 6'd0; bw(CA, 8'h01); repeat (4) @(negedge clk);
    nvm_addr = 6'd9; bw(CA, 8'h01);
    rd(DA, v); chk(v == 8'h6E, "R11 stored", v, 8'h6E);
    repeat (4) @(negedge clk);

    rd(6'h10, v); chk(v == 8'h00, "R12 unmapped", v, 0);
    rd(6'h3F, v); chk(v == 8'h00, "R12 unmapped top", v, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule